// File: doc/BRIEF.md
# Stable Marked-First Array Packer

This block takes a fixed-size array of data words, each tagged by one mark bit, and reorders it. All marked words are placed at the front and all unmarked words at the back. Words keep their original relative order inside each of the two groups. It also reports how many words carried the mark. A single-cycle start pulse captures the whole array and its marks in parallel. After a fixed latency the packed array and the count appear on the outputs, and a one-cycle done pulse marks their arrival.

Internally a log-step (Hillis-Steele) inclusive scan engine runs twice. The first pass runs over the mark indicators and gives each marked word its 0-based rank, which is its scan value minus one; the last value of this pass is the marked count m. The second pass runs over the inverted indicators and gives each unmarked word the slot m plus its scan value minus one. A scatter network then moves every word to its slot. Both passes reuse one engine. One pass takes log2(N) cycles, so a full operation takes 2*log2(N) cycles.

Top module: `stable_pack`

## Requirements
- R1: After reset, `dout` is all zero, `count` is zero and `done` is low.
- R2: A `start` sampled high while the block is idle captures `din` and `mark_in`. `done` is low in the cycle after the 2*log2(N)-1 th rising edge following the capturing edge, and high in the cycle after the 2*log2(N) th edge (8th edge for N=16).
- R3: When `done` rises, `count` equals the number of set bits in the captured `mark_in`.
- R4: Output slots 0 to count-1 hold the marked words in ascending order of their input index. Slot j is `dout[j*W +: W]`, word i is `din[i*W +: W]`, and word i is marked when `mark_in[i]` is 1.
- R5: Output slots count to N-1 hold the unmarked words in ascending order of their input index.
- R6: With no word marked, `dout` equals the captured `din` and `count` is 0.
- R7: With every word marked, `dout` equals the captured `din` and `count` equals N.
- R8: `start` raised while an operation is in progress is ignored. The result belongs to the first capture, and no second `done` pulse follows.
- R9: `done` is high for exactly one cycle. `dout` and `count` change only in the cycle `done` rises and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture request, honoured only while idle |
| din | input | N*W | Input words, word i at bits i*W +: W |
| mark_in | input | N | Mark bit per input word |
| dout | output | N*W | Packed words, slot j at bits j*W +: W |
| count | output | log2(N)+1 | Number of marked words in the last result |
| done | output | 1 | One-cycle pulse when a new result is presented |

## Verification
Two of the block's functions can fall in the same cycle. One is the arrival of a fresh `start` while the two scan passes are still running. The other is the completion cycle, in which the idle state can already accept the next capture. The bench provokes the first case by pulsing `start` with a different array and different marks in the middle of a run. It judges the outcome by comparing the result against a stable partition of the first array only, and by confirming that no second `done` pulse appears over the following cycles. Random mark patterns and the empty, full and single-mark cases are each judged against a behavioural stable partition computed in the bench.

// File: rtl/pack_pkg.sv
`timescale 1ns/1ps
package pack_pkg;
    typedef enum logic [0:0] {
        PK_IDLE = 1'b0,
        PK_RUN  = 1'b1
    } pk_state_e;
endpackage

// File: rtl/pack_scan_step.sv
`timescale 1ns/1ps
// One level of a log-step inclusive scan: element i adds element i-stride.
module pack_scan_step #(
    parameter int N   = 16,
    parameter int CW  = 5,
    parameter int LVW = 2
) (
    input  logic [N*CW-1:0] vec_in,
    input  logic [LVW-1:0]  level,
    output logic [N*CW-1:0] vec_out
);
    int stride;

    always_comb begin
        stride  = 1 << level;
        vec_out = vec_in;
        for (int i = 0; i < N; i++) begin
            if (i >= stride) begin
                vec_out[i*CW +: CW] = vec_in[i*CW +: CW] + vec_in[(i-stride)*CW +: CW];
            end
        end
    end
endmodule

// File: rtl/pack_scatter.sv
`timescale 1ns/1ps
// Moves each word to its 0-based destination derived from the two scans.
module pack_scatter #(
    parameter int N  = 16,
    parameter int W  = 8,
    parameter int CW = 5
) (
    input  logic [N*W-1:0]  data,
    input  logic [N-1:0]    mark,
    input  logic [N*CW-1:0] rank_m,
    input  logic [N*CW-1:0] rank_u,
    output logic [N*W-1:0]  packed_out,
    output logic [CW-1:0]   total
);
    logic [CW-1:0] dest [N];

    always_comb begin
        total = rank_m[(N-1)*CW +: CW];
        for (int i = 0; i < N; i++) begin
            if (mark[i]) begin
                dest[i] = rank_m[i*CW +: CW] - 1'b1;
            end else begin
                dest[i] = total + rank_u[i*CW +: CW] - 1'b1;
            end
        end
        packed_out = '0;
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                if (dest[i] == CW'(j)) begin
                    packed_out[j*W +: W] = packed_out[j*W +: W] | data[i*W +: W];
                end
            end
        end
    end
endmodule

// File: rtl/stable_pack.sv
`timescale 1ns/1ps
module stable_pack
    import pack_pkg::*;
#(
    parameter int N = 16,
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [N*W-1:0]       din,
    input  logic [N-1:0]         mark_in,
    output logic [N*W-1:0]       dout,
    output logic [$clog2(N):0]   count,
    output logic                 done
);
    localparam int LV  = $clog2(N);
    localparam int CW  = LV + 1;
    localparam int LVW = (LV > 1) ? $clog2(LV) : 1;

    typedef struct packed {
        pk_state_e        st;
        logic             phase;
        logic [LVW-1:0]   level;
        logic [N*W-1:0]   data;
        logic [N-1:0]     mark;
        logic [N*CW-1:0]  scan;
        logic [N*CW-1:0]  rank_m;
        logic [N*W-1:0]   dout;
        logic [CW-1:0]    count;
        logic             done;
    } regs_t;

    regs_t q, d;

    logic [N*CW-1:0] step_out;
    logic [N*W-1:0]  packed_w;
    logic [CW-1:0]   total_w;
    logic [N-1:0]    mark_hold;
    logic            busy;

    function automatic logic [N*CW-1:0] to_ind(input logic [N-1:0] bits);
        logic [N*CW-1:0] v;
        v = '0;
        for (int i = 0; i < N; i++) begin
            v[i*CW] = bits[i];
        end
        return v;
    endfunction

    pack_scan_step #(.N(N), .CW(CW), .LVW(LVW)) u_step (
        .vec_in  (q.scan),
        .level   (q.level),
        .vec_out (step_out)
    );

    pack_scatter #(.N(N), .W(W), .CW(CW)) u_scatter (
        .data       (q.data),
        .mark       (q.mark),
        .rank_m     (q.rank_m),
        .rank_u     (step_out),
        .packed_out (packed_w),
        .total      (total_w)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            PK_IDLE: begin
                if (start) begin
                    d.data  = din;
                    d.mark  = mark_in;
                    d.scan  = to_ind(mark_in);
                    d.phase = 1'b0;
                    d.level = '0;
                    d.st    = PK_RUN;
                end
            end
            PK_RUN: begin
                if (q.level == LVW'(LV-1)) begin
                    if (!q.phase) begin
                        d.rank_m = step_out;
                        d.scan   = to_ind(~q.mark);
                        d.phase  = 1'b1;
                        d.level  = '0;
                    end else begin
                        d.dout  = packed_w;
                        d.count = total_w;
                        d.done  = 1'b1;
                        d.st    = PK_IDLE;
                    end
                end else begin
                    d.scan  = step_out;
                    d.level = q.level + 1'b1;
                end
            end
            default: d.st = PK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dout      = q.dout;
    assign count     = q.count;
    assign done      = q.done;
    assign mark_hold = q.mark;
    assign busy      = (q.st == PK_RUN);
endmodule

// File: rtl/stable_pack_chk.sv
`timescale 1ns/1ps
module stable_pack_chk #(
    parameter int N = 16,
    parameter int W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic [$clog2(N):0] count,
    input logic [N*W-1:0]     dout,
    input logic [N-1:0]       mark_hold,
    input logic               busy
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(dout) && $stable(count)));

    // R3
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(count) == $countones(mark_hold)));

    // R8
    busy_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mark_hold));

    // R7
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(count) <= N));
endmodule

bind stable_pack stable_pack_chk #(.N(N), .W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .count     (count),
    .dout      (dout),
    .mark_hold (mark_hold),
    .busy      (busy)
);

// File: tb/stable_pack_bench.sv
`timescale 1ns/1ps
module stable_pack_bench;
    localparam int N  = 16;
    localparam int W  = 8;
    localparam int LV = $clog2(N);
    localparam int LAT = 2 * LV;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [N*W-1:0]     din = '0;
    logic [N-1:0]       mark_in = '0;
    logic [N*W-1:0]     dout;
    logic [LV:0]        count;
    logic               done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    stable_pack #(.N(N), .W(W)) u_stable_pack (
        .clk(clk), .rst_n(rst_n), .start(start), .din(din),
        .mark_in(mark_in), .dout(dout), .count(count), .done(done)
    );

    task automatic chk(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N*W-1:0] ref_pack(input logic [N*W-1:0] d, input logic [N-1:0] m);
        logic [N*W-1:0] r;
        int k;
        r = '0;
        k = 0;
        for (int i = 0; i < N; i++) if (m[i]) begin r[k*W +: W] = d[i*W +: W]; k++; end
        for (int i = 0; i < N; i++) if (!m[i]) begin r[k*W +: W] = d[i*W +: W]; k++; end
        return r;
    endfunction

    function automatic logic [N*W-1:0] rand_data();
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) r[i*W +: W] = W'($urandom);
        return r;
    endfunction

    // Runs one operation; optional interfering start in mid-run.
    task automatic run_check(input logic [N*W-1:0] d, input logic [N-1:0] m,
                             input bit interfere, input string tag);
        logic [N*W-1:0] exp_d;
        logic [N*W-1:0] held;
        exp_d = ref_pack(d, m);
        @(negedge clk);
        din = d; mark_in = m; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c < LAT; c++) begin
            if (interfere && c == 3) begin
                @(negedge clk);
                din = ~d; mark_in = ~m; start = 1'b1;
                @(posedge clk);
                @(negedge clk);
                start = 1'b0;
            end else begin
                @(posedge clk);
            end
        end
        @(negedge clk);
        chk({tag, " R2 done low before latency"}, (N*W)'(done), '0);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R2 done at latency"}, (N*W)'(done), (N*W)'(1));
        chk({tag, " R3 count"}, (N*W)'(count), (N*W)'($countones(m)));
        chk({tag, " R4 R5 packed order"}, dout, exp_d);
        held = dout;
        @(negedge clk);
        chk({tag, " R9 done single cycle"}, (N*W)'(done), '0);
        chk({tag, " R9 output held"}, dout, held);
        din = '0; mark_in = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 dout reset", dout, '0);
        chk("R1 count reset", (N*W)'(count), '0);
        chk("R1 done reset", (N*W)'(done), '0);
    endtask

    task automatic t_none();
        logic [N*W-1:0] d;
        d = rand_data();
        run_check(d, '0, 1'b0, "R6 none marked");
        chk("R6 output equals input", dout, d);
    endtask

    task automatic t_all();
        logic [N*W-1:0] d;
        d = rand_data();
        run_check(d, '1, 1'b0, "R7 all marked");
        chk("R7 output equals input", dout, d);
        chk("R7 count equals N", (N*W)'(count), (N*W)'(N));
    endtask

    task automatic t_patterns();
        logic [N*W-1:0] d;
        for (int i = 0; i < N; i++) d[i*W +: W] = W'(i + 1);
        run_check(d, 16'hAAAA, 1'b0, "R4 alternating");
        run_check(d, 16'h8000, 1'b0, "R4 last only");
        run_check(d, 16'h0001, 1'b0, "R5 first only");
        run_check(d, 16'h00FF, 1'b0, "R5 low half");
        run_check(d, 16'hFF00, 1'b0, "R4 high half");
    endtask

    task automatic t_busy();
        logic [N*W-1:0] d;
        d = rand_data();
        run_check(d, 16'h3C5A, 1'b1, "R8 busy start");
        for (int c = 0; c < 3 * LAT; c++) begin
            @(negedge clk);
            chk("R8 no second done", (N*W)'(done), '0);
        end
    endtask

    task automatic t_random();
        for (int r = 0; r < 20; r++) begin
            run_check(rand_data(), N'($urandom), 1'b0, "R4 R5 random");
        end
    endtask

    task automatic t_back_to_back();
        logic [N*W-1:0] d;
        d = rand_data();
        run_check(d, 16'h0F0F, 1'b0, "R9 first of pair");
        run_check(rand_data(), 16'h1248, 1'b0, "R9 second of pair");
    endtask

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_none();
        t_all();
        t_patterns();
        t_busy();
        t_random();
        t_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule